// File: doc/BRIEF.md
# Synthesizer Configuration Loader

This block holds the divider and test-select settings of a frequency synthesizer and accepts them from two sources. A set of parallel pins carries the feedback-divider value and the output-divider code, qualified by a parallel strobe. A three-wire serial port (clock, data, load strobe) carries a twelve-bit word that also sets a three-bit test-select code. The latched values drive the dividers and the test multiplexer elsewhere in the chip.

All pins are asynchronous to the internal clock and pass through two-flop synchronizers. Edges of the serial clock are detected in the internal domain. Both strobes behave as level-transparent latch enables with opposite polarities. The parallel strobe has priority. While it is low the parallel pins own the configuration and the test code is held at zero. After reset the configuration is loaded once from the parallel pins, so a board that ties the strobe high still starts from its strapped value.

Top module: `cfg_loader`

## Requirements
- R1: After reset is released and the synchronizers have filled, the outputs hold the parallel pin values and the test code is 000, even with the parallel strobe held high.
- R2: While the parallel strobe is low, the feedback and output divider outputs follow the parallel pins.
- R3: While the parallel strobe is high and the serial load strobe is low, changes on the parallel pins have no effect on the outputs. The value present before the strobe rose is kept.
- R4: While the parallel strobe is low, the test code output is 000, whatever the serial port held before.
- R5: Each rising edge of the serial clock shifts the serial data bit into a 12-bit register. A frame is sent in this order: test bits 2,1,0, then output-divider bits 1,0, then feedback bits 6 down to 0, most significant bit first. After a load, test = bits 11:9, output divider = bits 8:7 and feedback divider = bits 6:0 of the register.
- R6: While the serial load strobe is high (and the parallel strobe is high), the outputs follow the shift register, including bits shifted during that time. After the strobe falls, further shifting has no effect on the outputs.
- R7: A serial load done while the parallel strobe is low has no effect. The outputs keep following the parallel pins.
- R8: A pin change reaches the outputs exactly three internal clock cycles after it is applied: two synchronizer stages and the configuration register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_i | input | 1 | Parallel strobe; low = parallel pins transparent (idle high) |
| par_m_i | input | 7 | Parallel feedback-divider value (idle all ones) |
| par_n_i | input | 2 | Parallel output-divider code (idle all ones) |
| ser_clk_i | input | 1 | Serial shift clock, rising edge active (idle low) |
| ser_dat_i | input | 1 | Serial data (idle low) |
| ser_load_i | input | 1 | Serial load strobe; high = transparent (idle low) |
| cfg_m_o | output | 7 | Latched feedback-divider value |
| cfg_n_o | output | 2 | Latched output-divider code |
| cfg_t_o | output | 3 | Latched test-select code |

## Verification
The hardest case to reach is a serial load strobe held high while more bits are shifted. That is when the outputs must track a shift register still in motion and then freeze at the falling strobe. The stimulus sends a full frame, raises the strobe, shifts one extra bit with the strobe still high, lowers it, and shifts again. A model of the shift register gives the expected value at each point. The stimulus also sends frames with the parallel strobe low, so the priority rule is tested against a full serial load.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int M_W     = 7;
    localparam int N_W     = 2;
    localparam int T_W     = 3;
    localparam int FRAME_W = T_W + N_W + M_W;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (shift_en) word_d = {word_q[W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_load_i,
    input  logic [M_W-1:0] par_m_i,
    input  logic [N_W-1:0] par_n_i,
    input  logic           ser_clk_i,
    input  logic           ser_dat_i,
    input  logic           ser_load_i,
    output logic [M_W-1:0] cfg_m_o,
    output logic [N_W-1:0] cfg_n_o,
    output logic [T_W-1:0] cfg_t_o
);
    localparam int PAR_W  = 1 + M_W + N_W;
    localparam int BOOT_W = $clog2(SYNC_STAGES + 2);
    localparam logic [BOOT_W-1:0] BOOT_AT = BOOT_W'(SYNC_STAGES);

    typedef struct packed {
        cfg_t              cfg;
        logic [BOOT_W-1:0] boot;
        logic              sc_prev;
    } state_t;

    logic [PAR_W-1:0] par_s;
    logic [2:0]       ser_s;
    logic             pl_s, sc_s, sd_s, sl_s;
    logic [M_W-1:0]   m_s;
    logic [N_W-1:0]   n_s;
    logic [FRAME_W-1:0] frame;
    logic             shift_en, boot_fire;
    state_t           st_d, st_q;

    cfg_sync #(.W(PAR_W), .STAGES(SYNC_STAGES), .RST_VAL({PAR_W{1'b1}})) u_par_sync (
        .clk(clk), .rst_n(rst_n),
        .din({par_load_i, par_m_i, par_n_i}), .dout(par_s)
    );

    cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_ser_sync (
        .clk(clk), .rst_n(rst_n),
        .din({ser_clk_i, ser_dat_i, ser_load_i}), .dout(ser_s)
    );

    assign {pl_s, m_s, n_s} = par_s;
    assign {sc_s, sd_s, sl_s} = ser_s;
    assign shift_en  = sc_s & ~st_q.sc_prev;
    assign boot_fire = (st_q.boot == BOOT_AT);

    cfg_shift #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_en(shift_en), .bit_in(sd_s), .word_o(frame)
    );

    always_comb begin
        st_d         = st_q;
        st_d.sc_prev = sc_s;
        if (st_q.boot <= BOOT_AT) st_d.boot = st_q.boot + 1'b1;
        if (!pl_s) begin
            st_d.cfg = '{t: '0, n: n_s, m: m_s};
        end else if (sl_s) begin
            st_d.cfg = cfg_t'(frame);
        end else if (boot_fire) begin
            st_d.cfg = '{t: '0, n: n_s, m: m_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg     <= '{t: '0, n: '1, m: '1};
            st_q.boot    <= '0;
            st_q.sc_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_m_o = st_q.cfg.m;
    assign cfg_n_o = st_q.cfg.n;
    assign cfg_t_o = st_q.cfg.t;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
    import cfg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               pl_s,
    input logic               sl_s,
    input logic               sc_s,
    input logic               sd_s,
    input logic               boot_fire,
    input logic [M_W-1:0]     m_s,
    input logic [N_W-1:0]     n_s,
    input logic [FRAME_W-1:0] frame,
    input logic [M_W-1:0]     cfg_m_o,
    input logic [N_W-1:0]     cfg_n_o,
    input logic [T_W-1:0]     cfg_t_o
);
    a_r4_test_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_s |=> cfg_t_o == '0);

    a_r2_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_s |=> (cfg_m_o == $past(m_s) && cfg_n_o == $past(n_s)));

    a_r6_ser_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_s && sl_s) |=> {cfg_t_o, cfg_n_o, cfg_m_o} == $past(frame));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_s && !sl_s && !boot_fire) |=> ($stable(cfg_m_o) && $stable(cfg_n_o) && $stable(cfg_t_o)));

    a_r5_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc_s) |=> frame[0] == $past(sd_s));

    a_r5_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sc_s) |=> $stable(frame));
endmodule

bind cfg_loader cfg_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pl_s(pl_s), .sl_s(sl_s), .sc_s(sc_s), .sd_s(sd_s),
    .boot_fire(boot_fire), .m_s(m_s), .n_s(n_s), .frame(frame),
    .cfg_m_o(cfg_m_o), .cfg_n_o(cfg_n_o), .cfg_t_o(cfg_t_o)
);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load_i = 1'b1;
    logic [6:0] par_m_i = 7'h2a;
    logic [1:0] par_n_i = 2'b01;
    logic       ser_clk_i = 1'b0;
    logic       ser_dat_i = 1'b0;
    logic       ser_load_i = 1'b0;
    logic [6:0] cfg_m_o;
    logic [1:0] cfg_n_o;
    logic [2:0] cfg_t_o;

    int unsigned vectors = 0;
    int unsigned fails = 0;
    bit          done = 1'b0;
    logic [11:0] sh_model = '0;
    logic [11:0] expect_cfg;

    always #4 clk = ~clk;

    cfg_loader uut (
        .clk(clk), .rst_n(rst_n), .par_load_i(par_load_i), .par_m_i(par_m_i),
        .par_n_i(par_n_i), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
        .ser_load_i(ser_load_i), .cfg_m_o(cfg_m_o), .cfg_n_o(cfg_n_o), .cfg_t_o(cfg_t_o)
    );

    function automatic logic [11:0] pack_cfg(logic [2:0] t, logic [1:0] n, logic [6:0] m);
        return {t, n, m};
    endfunction

    function automatic logic [11:0] shift_model(logic [11:0] cur, logic b);
        return {cur[10:0], b};
    endfunction

    task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] outs();
        return {cfg_t_o, cfg_n_o, cfg_m_o};
    endfunction

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        ser_dat_i = b;
        wait_cyc(4);
        ser_clk_i = 1'b1;
        sh_model = shift_model(sh_model, b);
        wait_cyc(4);
        ser_clk_i = 1'b0;
        wait_cyc(4);
    endtask

    task automatic send_frame(logic [11:0] w);
        for (int i = 11; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_load();
        ser_load_i = 1'b1;
        wait_cyc(6);
        ser_load_i = 1'b0;
        wait_cyc(6);
    endtask

    task automatic par_load(logic [6:0] m, logic [1:0] n);
        par_load_i = 1'b0;
        par_m_i = m;
        par_n_i = n;
        wait_cyc(6);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        logic [6:0] rm;
        logic [1:0] rn;
        logic [11:0] fw;
        seed_v = $urandom(32'h0c0f_1e55);

        // R1: strapped value loaded after reset with strobe high
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(6);
        chk("R1 boot load", outs(), pack_cfg(3'b000, 2'b01, 7'h2a));

        // R8: latency of exactly three cycles
        par_load_i = 1'b0;
        wait_cyc(6);
        par_m_i = 7'h11;
        par_n_i = 2'b10;
        wait_cyc(2);
        chk("R8 not yet", outs(), pack_cfg(3'b000, 2'b01, 7'h2a));
        wait_cyc(1);
        chk("R8 arrived", outs(), pack_cfg(3'b000, 2'b10, 7'h11));
        par_load_i = 1'b1;
        wait_cyc(6);

        // R5: directed serial frame
        fw = pack_cfg(3'b101, 2'b10, 7'h4c);
        send_frame(fw);
        pulse_load();
        chk("R5 frame fields", outs(), fw);

        // R4: parallel strobe low clears test code
        par_load(7'h33, 2'b00);
        chk("R4 test cleared", outs(), pack_cfg(3'b000, 2'b00, 7'h33));
        par_load_i = 1'b1;
        wait_cyc(6);
        chk("R4 stays clear", outs(), pack_cfg(3'b000, 2'b00, 7'h33));

        // R6: transparent serial latch, then frozen
        send_frame(pack_cfg(3'b011, 2'b01, 7'h05));
        ser_load_i = 1'b1;
        wait_cyc(6);
        chk("R6 transparent", outs(), sh_model);
        send_bit(1'b1);
        chk("R6 tracks extra shift", outs(), sh_model);
        expect_cfg = sh_model;
        ser_load_i = 1'b0;
        wait_cyc(6);
        send_bit(1'b0);
        send_bit(1'b1);
        chk("R6 frozen after fall", outs(), expect_cfg);

        for (int it = 0; it < 40; it++) begin
            rm = 7'($urandom);
            rn = 2'($urandom);
            case ($urandom % 3)
                0: begin
                    par_load(rm, rn);
                    chk("R2 follow pins", outs(), pack_cfg(3'b000, rn, rm));
                    par_load_i = 1'b1;
                    wait_cyc(6);
                    par_m_i = ~rm;
                    par_n_i = ~rn;
                    wait_cyc(6);
                    chk("R3 pins ignored", outs(), pack_cfg(3'b000, rn, rm));
                end
                1: begin
                    fw = 12'($urandom);
                    send_frame(fw);
                    pulse_load();
                    chk("R5 random frame", outs(), fw);
                end
                default: begin
                    par_load(rm, rn);
                    send_frame(12'($urandom));
                    pulse_load();
                    chk("R7 serial ignored", outs(), pack_cfg(3'b000, rn, rm));
                    par_load_i = 1'b1;
                    wait_cyc(6);
                    chk("R7 after release", outs(), pack_cfg(3'b000, rn, rm));
                end
            endcase
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule